// File: doc/BRIEF.md
# Prescaled Reloadable 16-bit Timer

This block is an up-counting 16-bit timer. It has three count sources. The first is a clock-enable pulse from a programmable prescaler. The second is falling edges on an external count pin. The third is the prescaler pulse, let through only while an external gate pin is high. The prescaler divides by 1, 2, 4, 6, 8, 12 or 24. It produces a one-cycle enable and never a derived clock, so the whole block runs on one clock.

When the counter passes 0xFFFF it sets a sticky overflow flag. It then either wraps to zero or loads a 16-bit reload value. A separate trigger pin can also load the reload value on its falling edge, whatever the count source is doing. Software reads and writes three values through plain strobed ports: the control byte, the counter and the reload value. It clears the flag with a one-cycle pulse. Bus decoding and interrupt routing belong to the surrounding system.

Top module: `ptmr_top`

## Requirements
- R1: After reset the control byte reads 0x00, the counter reads 0x0000, the reload value reads 0x0000 and the overflow flag is 0. The timer does not count.
- R2: The control byte holds the prescale select in bits [2:0], the reload mode in bits [4:3] and the count source in bits [6:5]. Bit 7 always reads 0.
- R3: Prescale select codes 000..110 divide by 1, 2, 4, 6, 8, 12 and 24. Code 111 divides by 1. A control write that changes the select restarts the prescaler. After K clock edges following that write, the counter has advanced by floor(K/N).
- R4: Count source 01 advances the counter by one on every prescaler pulse.
- R5: Count source 00 holds the counter unchanged.
- R6: Count source 10 advances the counter once per falling edge of the count pin. The pin passes through a two-flop synchronizer, so an edge takes effect within four clocks. Rising edges have no effect.
- R7: Count source 11 advances on prescaler pulses only while the synchronized gate pin is 1. With the gate at 0 the counter holds.
- R8: The counter overflows when it advances from 0xFFFF. Overflow sets the overflow flag, and the flag stays set until a flag-clear pulse. An overflow in the same cycle as a clear leaves the flag set. When reload mode is not 10, the counter wraps to 0x0000.
- R9: With reload mode 10, an overflow loads the reload value into the counter.
- R10: With reload mode 11, a falling edge of the synchronized trigger pin loads the reload value, whatever the count source. Rising edges have no effect. Overflow wraps to 0x0000. Reload modes 00 and 01 never reload.
- R11: A software counter write takes precedence over a reload and over an increment in the same cycle. No overflow is recorded in that cycle.
- R12: A reload-value write is returned on the reload read port in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWe | input | 1 | Control byte write strobe |
| ctrlWdata | input | 8 | Control byte write data |
| ctrlRdata | output | 8 | Control byte read value |
| cntWe | input | 1 | Counter write strobe |
| cntWdata | input | 16 | Counter write data |
| cntRdata | output | 16 | Counter value |
| rldWe | input | 1 | Reload value write strobe |
| rldWdata | input | 16 | Reload value write data |
| rldRdata | output | 16 | Reload value |
| flagClr | input | 1 | One-cycle pulse that clears the overflow flag |
| ovfFlag | output | 1 | Sticky overflow flag |
| cntPin | input | 1 | External count pin (asynchronous) |
| gatePin | input | 1 | External gate pin (asynchronous, active high) |
| trigPin | input | 1 | External reload trigger pin (asynchronous) |

## Verification
The hardest situation to reach is a collision on the one cycle in which the counter leaves 0xFFFF. On that cycle a software counter write, or a flag-clear pulse, lands together with the overflow. The stimulus gets there by loading 0xFFFE while the counter is stopped. It then restarts the prescaler at divide-by-1, which makes the overflow cycle known exactly, and places the colliding strobe on the second edge. The prescaler ratios need an exact phase to check. Each counting window therefore first writes a different select, so that the final write is sure to restart the divider. Randomized windows, ratios and gate levels are then compared with floor(K/N).

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

  typedef enum logic [1:0] {
    SRC_STOP  = 2'b00,
    SRC_TICK  = 2'b01,
    SRC_PIN   = 2'b10,
    SRC_GATED = 2'b11
  } srcSel_e;

  // bit 7 spare, [6:5] source, [4:3] reload mode, [2:0] prescale
  typedef struct packed {
    logic       spare;
    srcSel_e    src;
    logic [1:0] rldMode;
    logic [2:0] psSel;
  } ctrlReg_t;

  typedef struct packed {
    logic swLoad;   // software counter write this cycle
    logic inc;      // advance the counter by one
    logic trigRld;  // trigger-pin reload this cycle
    logic autoRld;  // overflow loads reload value
  } strobe_t;

  localparam int MAX_DIV = 24;
  localparam int DIV_W   = $clog2(MAX_DIV);

  // terminal count of the divider (ratio - 1)
  function automatic logic [DIV_W-1:0] divLimit(input logic [2:0] sel);
    logic [DIV_W-1:0] lim;
    case (sel)
      3'b001:  lim = DIV_W'(1);
      3'b010:  lim = DIV_W'(3);
      3'b011:  lim = DIV_W'(5);
      3'b100:  lim = DIV_W'(7);
      3'b101:  lim = DIV_W'(11);
      3'b110:  lim = DIV_W'(MAX_DIV - 1);
      default: lim = '0;
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/ptmr_sync.sv
module ptmr_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       chain[s] <= '0;
      else if (s == 0) chain[s] <= asyncIn;
      else             chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/ptmr_ctrl.sv
module ptmr_ctrl
  import ptmr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWe,
  input  logic [7:0] ctrlWdata,
  input  logic       cntWe,
  input  logic       cntPinS,
  input  logic       gatePinS,
  input  logic       trigPinS,
  output ctrlReg_t   ctrlQ,
  output strobe_t    strobe
);

  logic [DIV_W-1:0] divCnt;
  logic             tick;
  logic             psChange;
  logic             cntPrev, trigPrev;
  logic             cntFall, trigFall;
  logic             incRaw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       ctrlQ <= '0;
    else if (ctrlWe) ctrlQ <= ctrlReg_t'(ctrlWdata & 8'h7F);
  end

  assign psChange = ctrlWe && (ctrlWdata[2:0] != ctrlQ.psSel);
  assign tick     = (divCnt == divLimit(ctrlQ.psSel));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         divCnt <= '0;
    else if (psChange) divCnt <= '0;
    else if (tick)     divCnt <= '0;
    else               divCnt <= divCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntPrev  <= 1'b0;
      trigPrev <= 1'b0;
    end else begin
      cntPrev  <= cntPinS;
      trigPrev <= trigPinS;
    end
  end

  assign cntFall  = cntPrev & ~cntPinS;
  assign trigFall = trigPrev & ~trigPinS;

  always_comb begin
    unique case (ctrlQ.src)
      SRC_TICK:  incRaw = tick;
      SRC_PIN:   incRaw = cntFall;
      SRC_GATED: incRaw = tick & gatePinS;
      default:   incRaw = 1'b0;
    endcase
  end

  always_comb begin
    strobe.swLoad  = cntWe;
    strobe.inc     = incRaw;
    strobe.trigRld = (ctrlQ.rldMode == 2'b11) && trigFall;
    strobe.autoRld = (ctrlQ.rldMode == 2'b10);
  end

endmodule

// File: rtl/ptmr_dp.sv
module ptmr_dp
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [CNT_W-1:0] cntWdata,
  input  logic             rldWe,
  input  logic [CNT_W-1:0] rldWdata,
  input  logic             flagClr,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-1:0] rldQ,
  output logic             ovfQ
);

  localparam logic [CNT_W-1:0] TOP = '1;

  logic atTop;
  logic ovfEvt;

  assign atTop  = (cntQ == TOP);
  assign ovfEvt = strobe.inc && atTop && !strobe.swLoad && !strobe.trigRld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cntQ <= '0;
    else if (strobe.swLoad)   cntQ <= cntWdata;
    else if (strobe.trigRld)  cntQ <= rldQ;
    else if (strobe.inc) begin
      if (atTop) cntQ <= strobe.autoRld ? rldQ : '0;
      else       cntQ <= cntQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      rldQ <= '0;
    else if (rldWe) rldQ <= rldWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        ovfQ <= 1'b0;
    else if (ovfEvt)  ovfQ <= 1'b1;
    else if (flagClr) ovfQ <= 1'b0;
  end

endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
  import ptmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWe,
  input  logic [7:0]       ctrlWdata,
  output logic [7:0]       ctrlRdata,
  input  logic             cntWe,
  input  logic [CNT_W-1:0] cntWdata,
  output logic [CNT_W-1:0] cntRdata,
  input  logic             rldWe,
  input  logic [CNT_W-1:0] rldWdata,
  output logic [CNT_W-1:0] rldRdata,
  input  logic             flagClr,
  output logic             ovfFlag,
  input  logic             cntPin,
  input  logic             gatePin,
  input  logic             trigPin
);

  localparam int PIN_N = 3;

  logic [PIN_N-1:0] pinSync;
  ctrlReg_t         ctrlQ;
  strobe_t          strobe;

  ptmr_sync #(.STAGES(SYNC_STAGES), .WIDTH(PIN_N)) i_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({trigPin, gatePin, cntPin}),
    .syncOut (pinSync)
  );

  ptmr_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlWe    (ctrlWe),
    .ctrlWdata (ctrlWdata),
    .cntWe     (cntWe),
    .cntPinS   (pinSync[0]),
    .gatePinS  (pinSync[1]),
    .trigPinS  (pinSync[2]),
    .ctrlQ     (ctrlQ),
    .strobe    (strobe)
  );

  ptmr_dp #(.CNT_W(CNT_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cntWdata (cntWdata),
    .rldWe    (rldWe),
    .rldWdata (rldWdata),
    .flagClr  (flagClr),
    .cntQ     (cntRdata),
    .rldQ     (rldRdata),
    .ovfQ     (ovfFlag)
  );

  assign ctrlRdata = ctrlQ;

endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input ctrlReg_t         ctrlQ,
  input strobe_t          strobe,
  input logic             cntWe,
  input logic [CNT_W-1:0] cntWdata,
  input logic [CNT_W-1:0] cntRdata,
  input logic [CNT_W-1:0] rldRdata,
  input logic             flagClr,
  input logic             ovfFlag
);

  localparam logic [CNT_W-1:0] TOP = '1;

  a_r5_stop_holds: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ.src == SRC_STOP && !cntWe && !strobe.trigRld) |=> $stable(cntRdata));

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !flagClr) |=> ovfFlag);

  a_r8_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.autoRld && strobe.inc && cntRdata == TOP && !cntWe && !strobe.trigRld)
      |=> (cntRdata == '0 && ovfFlag));

  a_r9_auto_reload: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.autoRld && strobe.inc && cntRdata == TOP && !cntWe && !strobe.trigRld)
      |=> (cntRdata == $past(rldRdata) && ovfFlag));

  a_r10_trig_reload: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.trigRld && !cntWe) |=> cntRdata == $past(rldRdata));

  a_r11_sw_wins: assert property (@(posedge clk) disable iff (!rstN)
    cntWe |=> cntRdata == $past(cntWdata));

  a_r3_div1_every_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ.src == SRC_TICK && (ctrlQ.psSel == 3'b000 || ctrlQ.psSel == 3'b111))
      |-> strobe.inc);

endmodule

bind ptmr_top ptmr_chk #(.CNT_W(CNT_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .ctrlQ    (ctrlQ),
  .strobe   (strobe),
  .cntWe    (cntWe),
  .cntWdata (cntWdata),
  .cntRdata (cntRdata),
  .rldRdata (rldRdata),
  .flagClr  (flagClr),
  .ovfFlag  (ovfFlag)
);

// File: tb/test_ptmr_top.sv
module test_ptmr_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWe = 1'b0;
  logic [7:0]  ctrlWdata = '0;
  logic [7:0]  ctrlRdata;
  logic        cntWe = 1'b0;
  logic [15:0] cntWdata = '0;
  logic [15:0] cntRdata;
  logic        rldWe = 1'b0;
  logic [15:0] rldWdata = '0;
  logic [15:0] rldRdata;
  logic        flagClr = 1'b0;
  logic        ovfFlag;
  logic        cntPin = 1'b1;
  logic        gatePin = 1'b0;
  logic        trigPin = 1'b1;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ptmr_top i_ptmr_top (
    .clk(clk), .rstN(rstN),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata), .ctrlRdata(ctrlRdata),
    .cntWe(cntWe), .cntWdata(cntWdata), .cntRdata(cntRdata),
    .rldWe(rldWe), .rldWdata(rldWdata), .rldRdata(rldRdata),
    .flagClr(flagClr), .ovfFlag(ovfFlag),
    .cntPin(cntPin), .gatePin(gatePin), .trigPin(trigPin)
  );

  function automatic int ratioOf(input logic [2:0] sel);
    case (sel)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 6;
      3'd4: return 8;
      3'd5: return 12;
      3'd6: return 24;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] ctrlByte(input logic [1:0] src, input logic [1:0] rld,
                                          input logic [2:0] ps);
    return {1'b0, src, rld, ps};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrCtrl(input logic [7:0] v);
    @(negedge clk); ctrlWe = 1'b1; ctrlWdata = v;
    @(negedge clk); ctrlWe = 1'b0;
  endtask

  task automatic wrCnt(input logic [15:0] v);
    @(negedge clk); cntWe = 1'b1; cntWdata = v;
    @(negedge clk); cntWe = 1'b0;
  endtask

  task automatic wrRld(input logic [15:0] v);
    @(negedge clk); rldWe = 1'b1; rldWdata = v;
    @(negedge clk); rldWe = 1'b0;
  endtask

  task automatic clrFlag();
    @(negedge clk); flagClr = 1'b1;
    @(negedge clk); flagClr = 1'b0;
  endtask

  // stop, preload, then start with a changed select so the divider restarts
  task automatic startRun(input logic [1:0] src, input logic [1:0] rld, input logic [2:0] ps,
                          input logic [15:0] start);
    wrCtrl(ctrlByte(2'b00, rld, ps ^ 3'b001));
    wrCnt(start);
    wrCtrl(ctrlByte(src, rld, ps));
  endtask

  task automatic stopAll();
    wrCtrl(8'h00);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 ctrl", ctrlRdata, 8'h00);
    check("R1 cnt", cntRdata, 16'h0000);
    check("R1 rld", rldRdata, 16'h0000);
    check("R1 flag", ovfFlag, 1'b0);
    idle(10);
    check("R1 stopped", cntRdata, 16'h0000);

    // R2 layout and spare bit
    wrCtrl(8'hFF);
    check("R2 spare bit", ctrlRdata, 8'h7F);
    stopAll();
    check("R2 readback", ctrlRdata, 8'h00);

    // R12 reload register
    wrRld(16'hA5C3);
    check("R12 reload readback", rldRdata, 16'hA5C3);

    // R3/R4 every ratio over a 48-edge window
    for (int s = 0; s < 8; s++) begin
      startRun(2'b01, 2'b00, 3'(s), 16'h0000);
      idle(48);
      check($sformatf("R3 R4 ratio sel %0d", s), cntRdata, 32'(48 / ratioOf(3'(s))));
    end

    // R5 stop holds
    stopAll();
    wrCnt(16'h1357);
    idle(30);
    check("R5 stop holds", cntRdata, 16'h1357);

    // R7 gate low then high
    gatePin = 1'b0;
    startRun(2'b11, 2'b00, 3'd1, 16'h0000);
    idle(20);
    check("R7 gate low holds", cntRdata, 16'h0000);
    gatePin = 1'b1;
    startRun(2'b11, 2'b00, 3'd1, 16'h0000);
    idle(20);
    check("R7 gate high counts", cntRdata, 16'd10);

    // random windows: ratio, window length, source and gate level
    for (int it = 0; it < 24; it++) begin
      logic [2:0]  ps;
      logic [1:0]  src;
      int          k;
      int          expv;
      ps = 3'($urandom % 8);
      k = 1 + int'($urandom % 120);
      src = ($urandom % 2) ? 2'b11 : 2'b01;
      gatePin = 1'($urandom % 2);
      startRun(src, 2'b00, ps, 16'h0000);
      idle(k);
      expv = (src == 2'b01 || gatePin) ? k / ratioOf(ps) : 0;
      check($sformatf("R3 R4 R7 random sel %0d k %0d", ps, k), cntRdata, 32'(expv));
    end
    gatePin = 1'b0;

    // R6 count pin falling edges only
    stopAll();
    wrCnt(16'h0000);
    wrCtrl(ctrlByte(2'b10, 2'b00, 3'd0));
    for (int i = 0; i < 5; i++) begin
      cntPin = 1'b0; idle(3);
      cntPin = 1'b1; idle(3);
    end
    idle(5);
    check("R6 falling edges counted", cntRdata, 16'd5);
    idle(10);
    check("R6 rising/steady no count", cntRdata, 16'd5);

    // R8 wrap and flag
    stopAll();
    clrFlag();
    startRun(2'b01, 2'b00, 3'd0, 16'hFFFE);
    idle(2);
    check("R8 wrap to zero", cntRdata, 16'h0000);
    check("R8 flag set", ovfFlag, 1'b1);
    stopAll();
    idle(3);
    check("R8 flag sticky", ovfFlag, 1'b1);
    clrFlag();
    check("R8 flag cleared", ovfFlag, 1'b0);

    // R8 overflow beats same-cycle clear
    startRun(2'b01, 2'b00, 3'd0, 16'hFFFE);
    flagClr = 1'b1;
    idle(2);
    flagClr = 1'b0;
    check("R8 set wins over clear", ovfFlag, 1'b1);
    check("R8 wrap during clear", cntRdata, 16'h0000);
    stopAll();
    clrFlag();

    // R9 auto reload
    wrRld(16'h1234);
    startRun(2'b01, 2'b10, 3'd0, 16'hFFFF);
    idle(1);
    check("R9 auto reload value", cntRdata, 16'h1234);
    check("R9 flag", ovfFlag, 1'b1);
    idle(1);
    check("R9 continues after reload", cntRdata, 16'h1235);
    stopAll();
    clrFlag();

    // R11 software write beats overflow reload
    startRun(2'b01, 2'b10, 3'd0, 16'hFFFE);
    idle(1);
    cntWe = 1'b1; cntWdata = 16'h0777;
    idle(1);
    cntWe = 1'b0;
    check("R11 sw write wins", cntRdata, 16'h0777);
    check("R11 no overflow recorded", ovfFlag, 1'b0);
    stopAll();

    // R10 trigger reload
    wrCtrl(ctrlByte(2'b00, 2'b11, 3'd0));
    wrCnt(16'h0055);
    wrRld(16'hABCD);
    trigPin = 1'b0; idle(2);
    wrCnt(16'h0055);
    trigPin = 1'b1; idle(6);
    check("R10 rising edge ignored", cntRdata, 16'h0055);
    trigPin = 1'b0; idle(6);
    check("R10 falling edge reloads", cntRdata, 16'hABCD);
    trigPin = 1'b1; idle(6);
    clrFlag();
    startRun(2'b01, 2'b11, 3'd0, 16'hFFFF);
    idle(1);
    check("R10 overflow wraps", cntRdata, 16'h0000);
    check("R10 overflow flag", ovfFlag, 1'b1);
    stopAll();

    // R10 modes 00 never reload on trigger
    wrCnt(16'h0042);
    trigPin = 1'b0; idle(6);
    check("R10 no reload in mode 00", cntRdata, 16'h0042);
    trigPin = 1'b1; idle(3);

    summary();
  end

endmodule